// File: doc/BRIEF.md
# Multi-Core Idle Level Coordinator

In a multi-core package, each core asks for an idle level, and this block decides which level each core may actually enter. Level 0 means the core is running. Level 1 gates the core's clock. Level 2 also has the I/O hub hold back interrupts. Level 3 also shuts down the clock generators that all cores share. Because level 3 removes a resource that the other cores share, a core gets level 3 only when every core has asked for it. Otherwise the core is held at level 2. The package-wide level is the shallowest level granted to any core.

A request is filtered before it is used. A new request must hold steady for a programmable number of clock edges before it becomes the core's target, so brief idle windows do not toggle the gating. A wake input brings a core back to level 0 on the next clock. The shared-clock shutdown is released combinationally as soon as any wake input is seen, so the shared clocks are running before any core clock is ungated.

The block drives one clock-gate enable per core, a package interrupt-block output and a package shared-clock-off output.

Top module: `idle_coord`

## Requirements
- R1: A cycle with `rst` high leaves every granted level at 0, the package level at 0, and every gate output (`core_clk_gate`, `irq_block`, `shared_clk_off`) low on the next cycle.
- R2: Levels are 2-bit binary: 0 running, 1 core clock gated, 2 interrupts held, 3 shared clocks off. Core i uses bits [2i+1:2i] of `req_lvl` and `grant_lvl`. A settled request of 0, 1 or 2 is granted unchanged.
- R3: A settled request of 3 is granted as 3 only when every core's settled request is 3. Otherwise it is granted as 2.
- R4: `pkg_lvl` always equals the minimum of all granted core levels.
- R5: `core_clk_gate[i]` is high exactly when the granted level of core i is 1 or more.
- R6: `irq_block` is high exactly when `pkg_lvl` is 2 or 3.
- R7: `shared_clk_off` is high exactly when `pkg_lvl` is 3 and no `wake` bit is high in the same cycle.
- R8: When `wake[i]` is high at a clock edge, the granted level of core i is 0 after that edge. At the same edge, any other core granted 3 drops to 2. The core's filter restarts, so a deep request must settle again.
- R9: A new request held for `settle_cycles`+1 consecutive clock edges becomes the target at the last of those edges, and the granted level changes one edge later.
- R10: A request held for fewer than `settle_cycles`+1 consecutive edges does not change the granted level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_lvl | input | 2*NUM_CORES | Requested idle level per core |
| wake | input | NUM_CORES | Per-core wake request |
| settle_cycles | input | CNT_W | Extra edges a request must hold before it is taken |
| grant_lvl | output | 2*NUM_CORES | Granted idle level per core |
| pkg_lvl | output | 2 | Package idle level |
| core_clk_gate | output | NUM_CORES | Per-core clock-gate enable |
| irq_block | output | 1 | Package interrupt blocking |
| shared_clk_off | output | 1 | Shared clock generator shutdown |

## Verification
The assertions check the following on every cycle:
- the package level is the minimum of the granted levels;
- level 3 is granted to all cores or to none;
- each gate output agrees with the levels;
- the shared-clock shutdown drops whenever a wake is present;
- a woken core reads level 0 after the edge;
- reset clears the outputs.

Only the bench scenarios can show the rest. These are the exact settling latency for a programmed count, a short request that is filtered out, the demotion values for each mix of requests, and the ordering in which the shared clocks restart one cycle before the core clock is ungated.

// File: rtl/idle_coord_pkg.sv
package idle_coord_pkg;

    localparam int LVL_W = 2;

    typedef enum logic [LVL_W-1:0] {
        LVL_RUN         = 2'd0,
        LVL_CORE_GATED  = 2'd1,
        LVL_IRQ_HELD    = 2'd2,
        LVL_SHARED_DOWN = 2'd3
    } idle_lvl_e;

    typedef struct packed {
        idle_lvl_e lvl;
        logic      irq_block;
        logic      shared_off;
    } pkg_state_t;

    function automatic idle_lvl_e lvl_min(input idle_lvl_e a, input idle_lvl_e b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic lvl_is_deep(input idle_lvl_e l);
        return l == LVL_SHARED_DOWN;
    endfunction

endpackage

// File: rtl/idle_req_filter.sv
module idle_req_filter
    import idle_coord_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  idle_lvl_e        req_in,
    input  logic             wake,
    input  logic [CNT_W-1:0] settle,
    output idle_lvl_e        target
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    idle_lvl_e        last_q;
    idle_lvl_e        target_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_next;
    logic             same;

    always_comb begin
        same = (req_in == last_q);
        if (!same)
            run_next = '0;
        else if (run_q != CNT_MAX)
            run_next = run_q + 1'b1;
        else
            run_next = run_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q   <= LVL_RUN;
            target_q <= LVL_RUN;
            run_q    <= '0;
        end else if (wake) begin
            last_q   <= req_in;
            target_q <= LVL_RUN;
            run_q    <= '0;
        end else begin
            last_q <= req_in;
            run_q  <= run_next;
            if (run_next >= settle)
                target_q <= req_in;
        end
    end

    assign target = target_q;

endmodule

// File: rtl/idle_barrier.sv
module idle_barrier
    import idle_coord_pkg::*;
#(
    parameter int NUM_CORES = 2
) (
    input  idle_lvl_e            target [NUM_CORES],
    input  logic [NUM_CORES-1:0] wake,
    output idle_lvl_e            grant_next [NUM_CORES]
);
    idle_lvl_e            eff [NUM_CORES];
    logic [NUM_CORES-1:0] deep_vec;
    logic                 all_deep;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_eff
        assign eff[c]      = wake[c] ? LVL_RUN : target[c];
        assign deep_vec[c] = lvl_is_deep(eff[c]);
    end

    assign all_deep = &deep_vec;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_grant
        always_comb begin
            if (deep_vec[c] && !all_deep)
                grant_next[c] = LVL_IRQ_HELD;
            else
                grant_next[c] = eff[c];
        end
    end

endmodule

// File: rtl/idle_pkg_combine.sv
module idle_pkg_combine
    import idle_coord_pkg::*;
#(
    parameter int NUM_CORES = 2
) (
    input  idle_lvl_e            grant [NUM_CORES],
    input  logic [NUM_CORES-1:0] wake,
    output logic [NUM_CORES-1:0] gate_en,
    output pkg_state_t           pkg
);
    idle_lvl_e lowest;

    always_comb begin
        lowest = LVL_SHARED_DOWN;
        for (int c = 0; c < NUM_CORES; c++)
            lowest = lvl_min(lowest, grant[c]);
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_gate
        assign gate_en[c] = (grant[c] != LVL_RUN);
    end

    always_comb begin
        pkg.lvl        = lowest;
        pkg.irq_block  = (lowest >= LVL_IRQ_HELD);
        pkg.shared_off = lvl_is_deep(lowest) && !(|wake);
    end

endmodule

// File: rtl/idle_coord.sv
module idle_coord
    import idle_coord_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int CNT_W     = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [LVL_W*NUM_CORES-1:0] req_lvl,
    input  logic [NUM_CORES-1:0]       wake,
    input  logic [CNT_W-1:0]           settle_cycles,
    output logic [LVL_W*NUM_CORES-1:0] grant_lvl,
    output logic [LVL_W-1:0]           pkg_lvl,
    output logic [NUM_CORES-1:0]       core_clk_gate,
    output logic                       irq_block,
    output logic                       shared_clk_off
);
    idle_lvl_e  target     [NUM_CORES];
    idle_lvl_e  grant_next [NUM_CORES];
    idle_lvl_e  grant_q    [NUM_CORES];
    pkg_state_t pkg_st;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        idle_req_filter #(.CNT_W(CNT_W)) u_filter (
            .clk    (clk),
            .rst    (rst),
            .req_in (idle_lvl_e'(req_lvl[c*LVL_W +: LVL_W])),
            .wake   (wake[c]),
            .settle (settle_cycles),
            .target (target[c])
        );

        always_ff @(posedge clk) begin
            if (rst)
                grant_q[c] <= LVL_RUN;
            else
                grant_q[c] <= grant_next[c];
        end

        assign grant_lvl[c*LVL_W +: LVL_W] = grant_q[c];
    end

    idle_barrier #(.NUM_CORES(NUM_CORES)) u_barrier (
        .target     (target),
        .wake       (wake),
        .grant_next (grant_next)
    );

    idle_pkg_combine #(.NUM_CORES(NUM_CORES)) u_combine (
        .grant   (grant_q),
        .wake    (wake),
        .gate_en (core_clk_gate),
        .pkg     (pkg_st)
    );

    assign pkg_lvl        = pkg_st.lvl;
    assign irq_block      = pkg_st.irq_block;
    assign shared_clk_off = pkg_st.shared_off;

endmodule

// File: rtl/idle_coord_chk.sv
module idle_coord_chk #(
    parameter int NUM_CORES = 2,
    parameter int CNT_W     = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NUM_CORES-1:0]   wake,
    input logic [2*NUM_CORES-1:0] grant_lvl,
    input logic [1:0]             pkg_lvl,
    input logic [NUM_CORES-1:0]   core_clk_gate,
    input logic                   irq_block,
    input logic                   shared_clk_off
);
    logic [NUM_CORES-1:0] deep;
    logic                 some_equal;

    always_comb begin
        some_equal = 1'b0;
        for (int c = 0; c < NUM_CORES; c++) begin
            deep[c] = (grant_lvl[2*c +: 2] == 2'd3);
            if (grant_lvl[2*c +: 2] == pkg_lvl)
                some_equal = 1'b1;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (grant_lvl == '0 && pkg_lvl == 2'd0 && core_clk_gate == '0
                 && !irq_block && !shared_clk_off)); // R1

    AST_DEEP_ALL_OR_NONE: assert property (@(posedge clk) disable iff (rst)
        ($countones(deep) == 0) || (deep == {NUM_CORES{1'b1}})); // R3

    AST_PKG_IS_GRANT: assert property (@(posedge clk) disable iff (rst)
        some_equal); // R4

    AST_IRQ_BLOCK_MATCH: assert property (@(posedge clk) disable iff (rst)
        irq_block == (pkg_lvl >= 2'd2)); // R6

    AST_SHARED_OFF_SAFE: assert property (@(posedge clk) disable iff (rst)
        shared_clk_off |-> (pkg_lvl == 2'd3 && wake == '0)); // R7

    AST_WAKE_RELEASES_SHARED: assert property (@(posedge clk) disable iff (rst)
        (|wake) |-> !shared_clk_off); // R7

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core_chk
        AST_PKG_NOT_ABOVE: assert property (@(posedge clk) disable iff (rst)
            pkg_lvl <= grant_lvl[2*c +: 2]); // R4

        AST_GATE_MATCH: assert property (@(posedge clk) disable iff (rst)
            core_clk_gate[c] == (grant_lvl[2*c +: 2] != 2'd0)); // R5

        AST_WAKE_TO_RUN: assert property (@(posedge clk) disable iff (rst)
            wake[c] |=> (grant_lvl[2*c +: 2] == 2'd0)); // R8
    end

endmodule

bind idle_coord idle_coord_chk #(.NUM_CORES(NUM_CORES), .CNT_W(CNT_W)) u_idle_coord_chk (.*);

// File: tb/test_idle_coord.sv
module test_idle_coord;

    localparam int  NUM_CORES = 2;
    localparam int  CNT_W     = 4;
    localparam time PERIOD    = 10;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [2*NUM_CORES-1:0] req_lvl = '0;
    logic [NUM_CORES-1:0]   wake = '0;
    logic [CNT_W-1:0]       settle_cycles = '0;
    logic [2*NUM_CORES-1:0] grant_lvl;
    logic [1:0]             pkg_lvl;
    logic [NUM_CORES-1:0]   core_clk_gate;
    logic                   irq_block;
    logic                   shared_clk_off;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    idle_coord #(.NUM_CORES(NUM_CORES), .CNT_W(CNT_W)) i_idle_coord (
        .clk            (clk),
        .rst            (rst),
        .req_lvl        (req_lvl),
        .wake           (wake),
        .settle_cycles  (settle_cycles),
        .grant_lvl      (grant_lvl),
        .pkg_lvl        (pkg_lvl),
        .core_clk_gate  (core_clk_gate),
        .irq_block      (irq_block),
        .shared_clk_off (shared_clk_off)
    );

    // Each entry: {r1, r0, g1, g0, pkg, gate[1:0], irq, off}
    localparam int NV = 9;
    localparam logic [13:0] VEC [NV] = '{
        {2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'b00, 1'b0, 1'b0},
        {2'd0, 2'd1, 2'd0, 2'd1, 2'd0, 2'b01, 1'b0, 1'b0},
        {2'd0, 2'd3, 2'd0, 2'd2, 2'd0, 2'b01, 1'b0, 1'b0},
        {2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'b11, 1'b1, 1'b1},
        {2'd1, 2'd3, 2'd1, 2'd2, 2'd1, 2'b11, 1'b0, 1'b0},
        {2'd3, 2'd2, 2'd2, 2'd2, 2'd2, 2'b11, 1'b1, 1'b0},
        {2'd2, 2'd1, 2'd2, 2'd1, 2'd1, 2'b11, 1'b0, 1'b0},
        {2'd3, 2'd0, 2'd2, 2'd0, 2'd0, 2'b10, 1'b0, 1'b0},
        {2'd2, 2'd2, 2'd2, 2'd2, 2'd2, 2'b11, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // R1: reset state
        edges(3);
        rst = 1'b0;
        check("R1 grants", 16'(grant_lvl), 16'h0);
        check("R1 pkg", 16'(pkg_lvl), 16'h0);
        check("R1 gates", 16'({core_clk_gate, irq_block, shared_clk_off}), 16'h0);

        // R2..R7: table walk with settle 0
        settle_cycles = '0;
        for (int v = 0; v < NV; v++) begin
            req_lvl = {VEC[v][13:12], VEC[v][11:10]};
            edges(3);
            check("R2_R3 grants", 16'(grant_lvl), 16'({VEC[v][9:8], VEC[v][7:6]}));
            check("R4 pkg", 16'(pkg_lvl), 16'(VEC[v][5:4]));
            check("R5 gate", 16'(core_clk_gate), 16'(VEC[v][3:2]));
            check("R6 irq", 16'(irq_block), 16'(VEC[v][1]));
            check("R7 off", 16'(shared_clk_off), 16'(VEC[v][0]));
        end

        // R9: latency with settle 3 (from 2,2 to 1,0)
        settle_cycles = 4'd3;
        edges(2);
        req_lvl = {2'd0, 2'd1};
        edges(4);
        check("R9 not yet", 16'(grant_lvl), 16'({2'd2, 2'd2}));
        edges(1);
        check("R9 taken", 16'(grant_lvl), 16'({2'd0, 2'd1}));

        // R10: short request filtered out
        req_lvl = {2'd2, 2'd2};
        edges(3);
        req_lvl = {2'd0, 2'd1};
        edges(10);
        check("R10 glitch ignored", 16'(grant_lvl), 16'({2'd0, 2'd1}));

        // R8 + R7 ordering: wake out of deep idle
        req_lvl = {2'd3, 2'd3};
        edges(8);
        check("R3 both deep", 16'(grant_lvl), 16'({2'd3, 2'd3}));
        check("R7 shared off", 16'(shared_clk_off), 16'h1);
        wake = 2'b01;
        req_lvl = {2'd3, 2'd0};
        #1;
        check("R7 released on wake", 16'(shared_clk_off), 16'h0);
        check("R7 core still gated", 16'(core_clk_gate[0]), 16'h1);
        edges(1);
        check("R8 woken core", 16'(grant_lvl[1:0]), 16'h0);
        check("R8 sibling demoted", 16'(grant_lvl[3:2]), 16'h2);
        check("R8 pkg running", 16'(pkg_lvl), 16'h0);
        check("R8 gate open", 16'(core_clk_gate[0]), 16'h0);
        wake = 2'b00;
        edges(6);
        check("R8 stays awake", 16'(grant_lvl), 16'({2'd2, 2'd0}));

        // R1: reset mid-operation
        rst = 1'b1;
        edges(1);
        rst = 1'b0;
        check("R1 reset again", 16'({grant_lvl, pkg_lvl, core_clk_gate, irq_block, shared_clk_off}), 16'h0);

        summary();
    end

endmodule